// File: doc/BRIEF.md
# Counter Channel Host Register Front End

This block sits between a byte-wide host bus and one 24-bit up/down counting core. Two host addresses are decoded: the data address and, next to it, the control address. A byte written to the control address is routed by its two upper field bits to one of four targets. Three of these targets are configuration registers (count mode, input/output control, index control), and each drives the core directly. The fourth target is a command decoder. It resets the byte pointer, clears flag groups in the core and moves values between the preset register, the core, the output latch and the filter clock prescaler.

The data address is accessed through a shared byte pointer that advances after every access. Writes fill the preset register and reads drain the output latch, in both cases least significant byte first. The host can only change the core count in two steps: it loads the preset, then issues a transfer command, which raises a one-cycle load pulse toward the core. A read of the control address returns the flag byte that the core supplies.

Top module: `cnt_host_regs`

## Requirements
- R1: While rst_ni is low, every register is cleared: preset, output latch, prescaler, the three configuration registers, the byte pointer, rdata_o and all pulse outputs.
- R2: reg_sel_i=0 addresses the data port and reg_sel_i=1 addresses the control port. Writes take effect at the rising clock edge on which wr_en_i is sampled high.
- R3: On a control write, bits [6:5] select the target: 0 command, 1 count mode, 2 input/output control, 3 index control. For targets 1 to 3, bits [4:0] are stored in the selected register and the other two registers keep their values.
- R4: Data writes place wdata_i into preset byte 0, 1 and 2 in turn (byte 0 is bits [7:0]). The pointer steps after each access and goes from byte 2 back to byte 0.
- R5: A data read returns output-latch byte 0, 1, 2 in turn on rdata_o, one cycle after the edge that samples rd_en_i. It uses the same pointer as writes.
- R6: A command byte with bit 0 set returns the pointer to byte 0.
- R7: In a command byte, bits [2:1]=2 raise clr_flags_o and bits [2:1]=3 raise clr_err_o, each for exactly one cycle after the command edge. Values 0 and 1 raise neither.
- R8: In a command byte, bits [4:3]=1 raise load_o for exactly one cycle after the command edge, while preset_o presents the value to load.
- R9: In a command byte, bits [4:3]=2 capture core_count_i into the output latch at the command edge. The latch changes at no other time.
- R10: In a command byte, bits [4:3]=3 copy preset byte 0 into psc_o.
- R11: A control read returns core_flags_i (bit 5 is direction, bit 4 is the noise error) on rdata_o one cycle later and does not move the pointer.
- R12: A control write to a configuration target performs no command action, even when its bits [4:0] match a command encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | 0 selects data port, 1 selects control port |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Host read byte, registered |
| core_count_i | input | 24 | Live count from the core |
| core_flags_i | input | 8 | Flag byte from the core |
| preset_o | output | 24 | Preset register value |
| load_o | output | 1 | One-cycle preset-to-counter load pulse |
| psc_o | output | 8 | Filter clock prescaler value |
| clr_flags_o | output | 1 | Pulse clearing borrow, carry, compare, sign and index flags |
| clr_err_o | output | 1 | Pulse clearing the noise error flag |
| mode_o | output | 5 | Count mode register |
| ioc_o | output | 5 | Input/output control register |
| idx_o | output | 5 | Index control register |

## Verification
The bench writes a fourth data byte to check the pointer wrap. A design without the wrap would write into a nonexistent byte 3 and leave byte 0 unchanged. It sends configuration bytes whose low bits match latch and load encodings: a decoder that ignores bits [6:5] would reload the latch or pulse load_o. It changes core_count_i after a latch command so that a latch that follows the live count shows up, and it places a flag read between two data reads to catch a pointer that advances on control reads. It also sends the [2:1]=1 code, which must clear nothing.

// File: rtl/cnt_host_pkg.sv
package cnt_host_pkg;
  localparam int CFG_W = 5;
  localparam int CFG_N = 3;

  typedef enum logic [1:0] {TGT_CMD = 2'd0, TGT_MODE = 2'd1, TGT_IOC = 2'd2, TGT_IDX = 2'd3} tgt_e;
  typedef enum logic [1:0] {CLR_NOP0 = 2'd0, CLR_NOP1 = 2'd1, CLR_FLAGS = 2'd2, CLR_ERR = 2'd3} clr_e;
  typedef enum logic [1:0] {XFR_NONE = 2'd0, XFR_LOAD = 2'd1, XFR_LATCH = 2'd2, XFR_PSC = 2'd3} xfr_e;

  typedef struct packed {
    logic             ptr_rst;
    logic             clr_flags;
    logic             clr_err;
    logic             do_load;
    logic             do_latch;
    logic             do_psc;
    logic [CFG_N-1:0] cfg_we;
  } act_t;
endpackage

// File: rtl/cnt_cmd_dec.sv
module cnt_cmd_dec import cnt_host_pkg::*; (
  input  logic       ctl_wr_i,
  input  logic [7:0] byte_i,
  output act_t       act_o
);
  tgt_e tgt;
  clr_e clr;
  xfr_e xfr;

  always_comb begin
    tgt   = tgt_e'(byte_i[6:5]);
    clr   = clr_e'(byte_i[2:1]);
    xfr   = xfr_e'(byte_i[4:3]);
    act_o = '0;
    if (ctl_wr_i) begin
      unique case (tgt)
        TGT_CMD: begin
          act_o.ptr_rst   = byte_i[0];
          act_o.clr_flags = (clr == CLR_FLAGS);
          act_o.clr_err   = (clr == CLR_ERR);
          act_o.do_load   = (xfr == XFR_LOAD);
          act_o.do_latch  = (xfr == XFR_LATCH);
          act_o.do_psc    = (xfr == XFR_PSC);
        end
        TGT_MODE: act_o.cfg_we[0] = 1'b1;
        TGT_IOC:  act_o.cfg_we[1] = 1'b1;
        TGT_IDX:  act_o.cfg_we[2] = 1'b1;
        default:  act_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cnt_byte_ptr.sv
module cnt_byte_ptr #(
  parameter int NBYTES = 3,
  parameter int PTR_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (clr_i)  ptr_o <= '0;
    else if (step_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/cnt_data_path.sv
module cnt_data_path #(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8,
  parameter int PTR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              dwr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              latch_i,
  input  logic              psc_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CNT_W-1:0]  preset_o,
  output logic [BYTE_W-1:0] psc_o,
  output logic [BYTE_W-1:0] rd_byte_o
);
  localparam int NBYTES = CNT_W / BYTE_W;

  logic [CNT_W-1:0] latch_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_preset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) preset_o[b*BYTE_W +: BYTE_W] <= '0;
      else if (dwr_i && (ptr_i == PTR_W'(b)))
        preset_o[b*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      psc_o   <= '0;
    end else begin
      if (latch_i) latch_q <= count_i;
      if (psc_i)   psc_o   <= preset_o[BYTE_W-1:0];
    end
  end

  always_comb begin
    rd_byte_o = '0;
    for (int b = 0; b < NBYTES; b++)
      if (ptr_i == PTR_W'(b)) rd_byte_o = latch_q[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/cnt_cfg_bank.sv
module cnt_cfg_bank #(
  parameter int N = 3,
  parameter int W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        we_i,
  input  logic [W-1:0]        d_i,
  output logic [N-1:0][W-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o[i] <= '0;
      else if (we_i[i]) q_o[i] <= d_i;
    end
  end
endmodule

// File: rtl/cnt_host_regs.sv
module cnt_host_regs import cnt_host_pkg::*; #(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_sel_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  core_count_i,
  input  logic [BYTE_W-1:0] core_flags_i,
  output logic [CNT_W-1:0]  preset_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] psc_o,
  output logic              clr_flags_o,
  output logic              clr_err_o,
  output logic [CFG_W-1:0]  mode_o,
  output logic [CFG_W-1:0]  ioc_o,
  output logic [CFG_W-1:0]  idx_o
);
  localparam int NBYTES = CNT_W / BYTE_W;
  localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic ctl_wr, dat_wr, dat_rd, flg_rd;
  act_t act;
  logic [PTR_W-1:0] ptr_q;
  logic [BYTE_W-1:0] latch_byte;
  logic [CFG_N-1:0][CFG_W-1:0] cfg_q;

  assign ctl_wr = wr_en_i & reg_sel_i;
  assign dat_wr = wr_en_i & ~reg_sel_i;
  assign dat_rd = rd_en_i & ~wr_en_i & ~reg_sel_i;
  assign flg_rd = rd_en_i & ~wr_en_i & reg_sel_i;

  cnt_cmd_dec u_dec (
    .ctl_wr_i (ctl_wr),
    .byte_i   (wdata_i[7:0]),
    .act_o    (act)
  );

  cnt_byte_ptr #(.NBYTES(NBYTES), .PTR_W(PTR_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (act.ptr_rst),
    .step_i (dat_wr | dat_rd),
    .ptr_o  (ptr_q)
  );

  cnt_data_path #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .PTR_W(PTR_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ptr_i     (ptr_q),
    .dwr_i     (dat_wr),
    .wdata_i   (wdata_i),
    .latch_i   (act.do_latch),
    .psc_i     (act.do_psc),
    .count_i   (core_count_i),
    .preset_o  (preset_o),
    .psc_o     (psc_o),
    .rd_byte_o (latch_byte)
  );

  cnt_cfg_bank #(.N(CFG_N), .W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (act.cfg_we),
    .d_i    (wdata_i[CFG_W-1:0]),
    .q_o    (cfg_q)
  );

  assign mode_o = cfg_q[0];
  assign ioc_o  = cfg_q[1];
  assign idx_o  = cfg_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      load_o      <= 1'b0;
      clr_flags_o <= 1'b0;
      clr_err_o   <= 1'b0;
    end else begin
      load_o      <= act.do_load;
      clr_flags_o <= act.clr_flags;
      clr_err_o   <= act.clr_err;
      if (dat_rd)      rdata_o <= latch_byte;
      else if (flg_rd) rdata_o <= core_flags_i;
    end
  end
endmodule

// File: rtl/cnt_host_chk.sv
module cnt_host_chk #(
  parameter int NBYTES = 3,
  parameter int PTR_W  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_sel_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [7:0]       wdata_i,
  input logic [7:0]       rdata_o,
  input logic [7:0]       core_flags_i,
  input logic [23:0]      preset_o,
  input logic             load_o,
  input logic             clr_flags_o,
  input logic             clr_err_o,
  input logic [4:0]       mode_o,
  input logic [PTR_W-1:0] ptr_q
);
  assert_ptr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_W'(NBYTES - 1));

  assert_load_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(wr_en_i && reg_sel_i && wdata_i[6:5] == 2'd0 && wdata_i[4:3] == 2'd1));

  assert_clr_err_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_err_o |-> $past(wr_en_i && reg_sel_i && wdata_i[6:5] == 2'd0 && wdata_i[2:1] == 2'd3));

  assert_clr_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_err_o && clr_flags_o));

  assert_preset_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i && !reg_sel_i) |-> $stable(preset_o));

  assert_mode_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i && reg_sel_i && wdata_i[6:5] == 2'd1) |-> $stable(mode_o));

  assert_flag_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && !wr_en_i && reg_sel_i) |-> rdata_o == $past(core_flags_i));
endmodule

bind cnt_host_regs cnt_host_chk #(.NBYTES(NBYTES), .PTR_W(PTR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_sel_i    (reg_sel_i),
  .wr_en_i      (wr_en_i),
  .rd_en_i      (rd_en_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .core_flags_i (core_flags_i),
  .preset_o     (preset_o),
  .load_o       (load_o),
  .clr_flags_o  (clr_flags_o),
  .clr_err_o    (clr_err_o),
  .mode_o       (mode_o),
  .ptr_q        (ptr_q)
);

// File: tb/sim_cnt_host_regs.sv
module sim_cnt_host_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_sel_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [23:0] core_count_i = '0;
  logic [7:0]  core_flags_i = '0;
  logic [23:0] preset_o;
  logic        load_o, clr_flags_o, clr_err_o;
  logic [7:0]  psc_o;
  logic [4:0]  mode_o, ioc_o, idx_o;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk_i = ~clk_i;

  cnt_host_regs u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_wr(logic [7:0] b);
    @(negedge clk_i); reg_sel_i = 1'b1; wr_en_i = 1'b1; wdata_i = b;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic dat_wr(logic [7:0] b);
    @(negedge clk_i); reg_sel_i = 1'b0; wr_en_i = 1'b1; wdata_i = b;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic host_rd(logic sel, logic [7:0] exp, string req);
    @(negedge clk_i); reg_sel_i = sel; rd_en_i = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk_i); rd_en_i = 1'b0;
  endtask

  // monitor: compares registered read data against the scoreboard queue
  initial begin
    forever begin
      @(posedge clk_i);
      if (rst_ni && rd_en_i && !wr_en_i) begin
        #2;
        if (exp_q.size() == 0) chk("R5_unexpected_read", 32'(rdata_o), 32'hFFFF);
        else chk(tag_q.pop_front(), 32'(rdata_o), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1_preset", 32'(preset_o), 0);
    chk("R1_cfg", {17'd0, mode_o, ioc_o, idx_o}, 0);
    chk("R1_pulses", {load_o, clr_flags_o, clr_err_o}, 0);
    chk("R1_rdata", 32'(rdata_o), 0);
    rst_ni = 1'b1;

    // R2 R4 preset written LSB first through data port
    dat_wr(8'h56); dat_wr(8'h34); dat_wr(8'h12);
    chk("R4_preset_fill", 32'(preset_o), 32'h123456);
    dat_wr(8'hAA);
    chk("R4_ptr_wrap", 32'(preset_o), 32'h1234AA);

    // R6 pointer reset
    ctl_wr(8'h01);
    dat_wr(8'h77);
    chk("R6_ptr_reset", 32'(preset_o), 32'h123477);

    // R8 load pulse one cycle
    ctl_wr(8'h08);
    chk("R8_load_high", 32'(load_o), 1);
    @(negedge clk_i);
    chk("R8_load_single", 32'(load_o), 0);

    // R9 latch, then read bytes LSB first (R5)
    core_count_i = 24'hABCDEF;
    ctl_wr(8'h11);
    core_count_i = 24'h000000;
    host_rd(1'b0, 8'hEF, "R5_rd_b0");
    host_rd(1'b0, 8'hCD, "R5_rd_b1");
    host_rd(1'b0, 8'hAB, "R5_rd_b2");
    host_rd(1'b0, 8'hEF, "R5_rd_wrap");

    // R10 prescaler from preset low byte
    ctl_wr(8'h18);
    chk("R10_psc", 32'(psc_o), 32'h77);

    // R7 flag clears
    ctl_wr(8'h04);
    chk("R7_clr_flags", {clr_flags_o, clr_err_o}, 2'b10);
    @(negedge clk_i);
    chk("R7_clr_flags_single", 32'(clr_flags_o), 0);
    ctl_wr(8'h06);
    chk("R7_clr_err", {clr_flags_o, clr_err_o}, 2'b01);
    ctl_wr(8'h02);
    chk("R7_clr_none", {clr_flags_o, clr_err_o}, 2'b00);

    // R3 R12 configuration writes with command-like low bits
    core_count_i = 24'h111111;
    ctl_wr(8'h35);
    chk("R3_mode", {mode_o, ioc_o, idx_o}, {5'h15, 5'h00, 5'h00});
    ctl_wr(8'h4A);
    chk("R12_no_load", 32'(load_o), 0);
    chk("R3_ioc", {mode_o, ioc_o, idx_o}, {5'h15, 5'h0A, 5'h00});
    ctl_wr(8'h63);
    chk("R3_idx", {mode_o, ioc_o, idx_o}, {5'h15, 5'h0A, 5'h03});
    chk("R12_preset_kept", 32'(preset_o), 32'h123477);
    ctl_wr(8'h01);
    host_rd(1'b0, 8'hEF, "R12_latch_kept");

    // R11 flag read leaves pointer alone
    core_flags_i = 8'h30;
    host_rd(1'b1, 8'h30, "R11_flags");
    host_rd(1'b0, 8'hCD, "R11_ptr_still");

    repeat (3) @(negedge clk_i);
    chk("R5_queue_drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule